// File: doc/BRIEF.md
# Packet ECRC Append Unit

This unit sits on the transmit side of a transaction-layer datapath. It receives packets as a valid/ready stream of 128-bit beats, with four 32-bit dword lanes per beat. Each beat carries start and end markers, and a count of the unused top lanes on the last beat. Every packet that is not a Type 0 configuration request leaves the unit with its digest-present header bit set. A CRC-32 over its header and payload dwords is appended as one extra dword.

The appended dword obeys the same lane alignment that payload data obeys. On a packet with payload it directly follows the last payload dword. On a packet without payload it lands where a single payload dword would have been placed, given the header size and the address alignment. When the dword does not fit in the last beat, the unit emits one extra beat and holds off the source for that cycle.

The unit is a three-state machine: `ST_IDLE` (waiting for a start beat), `ST_BODY` (inside a packet) and `ST_EXTRA` (emitting an appended CRC beat).
- `ST_IDLE` to `ST_BODY`: a start beat without an end marker is accepted.
- `ST_IDLE` to `ST_IDLE`: a single-beat packet is accepted and the CRC fits in its beat, or the packet is exempt. A beat without a start marker is discarded.
- `ST_IDLE` or `ST_BODY` to `ST_EXTRA`: the end beat is accepted and the CRC overflows it.
- `ST_BODY` to `ST_IDLE`: the end beat is accepted and no overflow occurs.
- `ST_EXTRA` to `ST_IDLE`: the extra beat is taken by the sink.

Top module: `ecrc_append`

## Requirements
- R1: A packet whose type field (dword 0 bits 28:24) is not 5'b00100 is emitted with dword 0 bit 15 (digest present) equal to 1. All other bits of the dword are unchanged.
- R2: The CRC is CRC-32 with polynomial 0x04C11DB7 and initial value 0xFFFFFFFF, and the register is inverted before it is placed in the stream.
  - Each dword is fed from bit 31 down to bit 0, header dwords first and then payload dwords.
  - Pad dwords are left out of the CRC.
  - Dword 0 bits 15 and 14 are fed as 1 whatever their value.
- R3: A packet with in_has_data=1 gets its CRC in the dword slot right after its last payload dword.
  - If the end beat has unused lanes, the CRC goes in lane 4-in_empty and out_empty is in_empty-1.
  - Otherwise an extra beat follows, with the CRC in lane 0 and out_empty=3.
- R4: A packet with in_has_data=0 gets its CRC at the single-payload position. The address bit is bit 2 of dword 2 for a 3-dword header (dword 0 bit 29 = 0) and bit 2 of dword 3 for a 4-dword header.
  - 3-dword header, address bit 2 = 1: lane 3 of the same beat, out_empty=0.
  - 3-dword header, bit 2 = 0: lane 3 becomes a zero pad, and an extra beat carries the CRC in lane 0 with out_empty=3.
  - 4-dword header, bit 2 = 0: an extra beat carries the CRC in lane 0.
  - 4-dword header, bit 2 = 1: an extra beat carries lane 0 = 0 and the CRC in lane 1, with out_empty=2.
- R5: A packet of type 5'b00100 passes through beat for beat with no CRC dword. Dword 0 bit 15 is forced to 0, and the end marker and empty count are unchanged.
- R6: An extra beat has out_sop=0 and out_eop=1, and in_ready is 0 for the cycle it is offered.
- R7: Lane i of a beat is data bits 32i+31:32i, and dword 0 is lane 0 of the start beat. The empty count gives the number of unused top lanes on an end beat. An input payload carries one pad dword between header and data when the header is 3 dwords with address bit 2 = 0, or 4 dwords with address bit 2 = 1. That pad is passed on unchanged.
- R8: A beat offered while no packet is open and without in_sop is accepted and discarded, and no output beat results.
- R9: While rst_n is low and just after it rises, out_valid is 0 and in_ready equals out_ready.
- R10: Under back-pressure an offered output beat stays valid until out_ready. No beat is lost or repeated, and outside an extra beat in_ready equals out_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat accepted this cycle |
| in_data | input | 128 | Four dword lanes, lane 0 lowest |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_empty | input | 2 | Unused top lanes on the last beat |
| in_has_data | input | 1 | Packet carries payload, valid with the start beat |
| out_valid | output | 1 | Output beat offered |
| out_ready | input | 1 | Sink takes the output beat |
| out_data | output | 128 | Output dword lanes |
| out_sop | output | 1 | First output beat of a packet |
| out_eop | output | 1 | Last output beat of a packet |
| out_empty | output | 2 | Unused top lanes on the last output beat |

## Verification
The hardest case to reach is an extra CRC beat that the sink stalls while the source already offers the next packet's start beat. This needs the input to stay held off across several cycles without losing or doubling either packet. The stimulus sweeps payload lengths across every end-beat fill level for both header sizes and both alignments, so each lane position and each overflow is hit. It then repeats mixed traffic with randomly toggled out_ready and back-to-back packets, so stalls land on extra beats with a waiting start beat. A discarded stray beat and exempt configuration packets with and without payload are placed between them.

// File: rtl/ecrc_pkg.sv
package ecrc_pkg;

    localparam int DW_W = 32;

    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

    localparam logic [4:0] TYPE_CFG0   = 5'b00100;
    localparam int         TD_BIT      = 15;
    localparam int         EP_BIT      = 14;
    localparam int         FMT4_BIT    = 29;
    localparam int         TYPE_LSB    = 24;
    localparam int         ADDR_QW_BIT = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BODY  = 2'd1,
        ST_EXTRA = 2'd2
    } ecrc_state_e;

    // One dword into the CRC register, bit 31 first.
    function automatic logic [31:0] crc_dword(input logic [31:0] crc_in,
                                              input logic [31:0] word);
        logic [31:0] acc;
        logic        fb;
        acc = crc_in;
        for (int b = DW_W - 1; b >= 0; b--) begin
            fb  = acc[31] ^ word[b];
            acc = {acc[30:0], 1'b0};
            if (fb) acc = acc ^ CRC_POLY;
        end
        return acc;
    endfunction

endpackage

// File: rtl/ecrc_hdr_decode.sv
module ecrc_hdr_decode
    import ecrc_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [LANES*DW_W-1:0] beat,
    output logic                  is_4dw,
    output logic                  is_cfg0,
    output logic                  qw_aligned
);

    logic [DW_W-1:0] dw0;
    logic [DW_W-1:0] addr_dw;
    logic            unused_hdr;

    assign dw0     = beat[0 +: DW_W];
    assign is_4dw  = dw0[FMT4_BIT];
    assign is_cfg0 = (dw0[TYPE_LSB +: 5] == TYPE_CFG0);

    // Address low dword sits in lane 3 for long headers, lane 2 otherwise.
    assign addr_dw    = is_4dw ? beat[3*DW_W +: DW_W] : beat[2*DW_W +: DW_W];
    assign qw_aligned = ~addr_dw[ADDR_QW_BIT];

    assign unused_hdr = ^beat;

endmodule

// File: rtl/ecrc_crc_lanes.sv
module ecrc_crc_lanes
    import ecrc_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [DW_W-1:0]       crc_in,
    input  logic [LANES*DW_W-1:0] beat,
    input  logic [LANES-1:0]      lane_en,
    input  logic                  force_var,
    output logic [DW_W-1:0]       crc_out
);

    logic [DW_W-1:0] chain [LANES+1];

    assign chain[0] = crc_in;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [DW_W-1:0] word;
        if (g == 0) begin : g_first
            // Variant header bits enter the CRC as ones.
            always_comb begin
                word = beat[0 +: DW_W];
                if (force_var) begin
                    word[TD_BIT] = 1'b1;
                    word[EP_BIT] = 1'b1;
                end
            end
        end else begin : g_rest
            assign word = beat[g*DW_W +: DW_W];
        end
        assign chain[g+1] = lane_en[g] ? crc_dword(chain[g], word) : chain[g];
    end

    assign crc_out = chain[LANES];

endmodule

// File: rtl/ecrc_slot.sv
module ecrc_slot #(
    parameter int LANES  = 4,
    parameter int CNT_W  = 3,
    parameter int SLOT_W = 4
) (
    input  logic              has_data,
    input  logic              is_4dw,
    input  logic              qw_aligned,
    input  logic [CNT_W-1:0]  valid_cnt,
    output logic [SLOT_W-1:0] slot
);

    // Slot counts dword positions from lane 0 of the end beat; values
    // of LANES and above fall into a following beat.
    always_comb begin
        if (has_data) begin
            slot = SLOT_W'(valid_cnt);
        end else if (is_4dw) begin
            slot = qw_aligned ? SLOT_W'(LANES) : SLOT_W'(LANES + 1);
        end else begin
            slot = qw_aligned ? SLOT_W'(LANES) : SLOT_W'(LANES - 1);
        end
    end

endmodule

// File: rtl/ecrc_append.sv
module ecrc_append
    import ecrc_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [LANES*DW_W-1:0]        in_data,
    input  logic                         in_sop,
    input  logic                         in_eop,
    input  logic [$clog2(LANES)-1:0]     in_empty,
    input  logic                         in_has_data,
    output logic                         out_valid,
    input  logic                         out_ready,
    output logic [LANES*DW_W-1:0]        out_data,
    output logic                         out_sop,
    output logic                         out_eop,
    output logic [$clog2(LANES)-1:0]     out_empty
);

    localparam int EMPTY_W = $clog2(LANES);
    localparam int CNT_W   = EMPTY_W + 1;
    localparam int SLOT_W  = EMPTY_W + 2;

    ecrc_state_e state_q, state_d;

    // Per-packet context captured from the start beat.
    logic              hdr4_q, align_q, hasd_q, exempt_q, second_q;
    logic [DW_W-1:0]   crc_q;
    logic [DW_W-1:0]   xcrc_q;
    logic [SLOT_W-1:0] xslot_q;

    logic              start, pkt_beat, in_fire;
    logic              dec_4dw, dec_cfg0, dec_al;
    logic              cur_4dw, cur_al, cur_hd, cur_ex, beat1;
    logic [CNT_W-1:0]  valid_cnt;
    logic [LANES-1:0]  lane_en;
    logic [DW_W-1:0]   crc_base, crc_new;
    logic [SLOT_W-1:0] slot;
    logic              do_crc, need_extra, fits;

    assign start    = (state_q == ST_IDLE) && in_sop;
    assign pkt_beat = (state_q == ST_BODY) || start;
    assign in_ready = out_ready && (state_q != ST_EXTRA);
    assign in_fire  = in_valid && in_ready && pkt_beat;

    ecrc_hdr_decode #(.LANES(LANES)) u_dec (
        .beat       (in_data),
        .is_4dw     (dec_4dw),
        .is_cfg0    (dec_cfg0),
        .qw_aligned (dec_al)
    );

    assign cur_4dw  = start ? dec_4dw     : hdr4_q;
    assign cur_al   = start ? dec_al      : align_q;
    assign cur_hd   = start ? in_has_data : hasd_q;
    assign cur_ex   = start ? dec_cfg0    : exempt_q;
    assign crc_base = start ? CRC_SEED    : crc_q;
    assign beat1    = !start && second_q;

    assign valid_cnt = in_eop ? (CNT_W'(LANES) - CNT_W'(in_empty)) : CNT_W'(LANES);

    // Lanes that feed the CRC: filled lanes that are not alignment pads.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            lane_en[i] = (CNT_W'(i) < valid_cnt);
            if (start && (i == LANES - 1) && !cur_4dw && cur_al && cur_hd) begin
                lane_en[i] = 1'b0;
            end
            if (beat1 && (i == 0) && cur_4dw && !cur_al) begin
                lane_en[i] = 1'b0;
            end
        end
    end

    ecrc_crc_lanes #(.LANES(LANES)) u_crc (
        .crc_in    (crc_base),
        .beat      (in_data),
        .lane_en   (lane_en),
        .force_var (start),
        .crc_out   (crc_new)
    );

    ecrc_slot #(.LANES(LANES), .CNT_W(CNT_W), .SLOT_W(SLOT_W)) u_slot (
        .has_data   (cur_hd),
        .is_4dw     (cur_4dw),
        .qw_aligned (cur_al),
        .valid_cnt  (valid_cnt),
        .slot       (slot)
    );

    assign do_crc     = pkt_beat && in_eop && !cur_ex;
    assign fits       = (slot < SLOT_W'(LANES));
    assign need_extra = do_crc && !fits;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Packet context and running CRC.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr4_q   <= 1'b0;
            align_q  <= 1'b0;
            hasd_q   <= 1'b0;
            exempt_q <= 1'b0;
            second_q <= 1'b0;
            crc_q    <= CRC_SEED;
            xcrc_q   <= '0;
            xslot_q  <= '0;
        end else if (in_fire) begin
            crc_q    <= crc_new;
            second_q <= start;
            if (start) begin
                hdr4_q   <= dec_4dw;
                align_q  <= dec_al;
                hasd_q   <= in_has_data;
                exempt_q <= dec_cfg0;
            end
            if (need_extra) begin
                xcrc_q  <= ~crc_new;
                xslot_q <= slot;
            end
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_fire) begin
                    if (!in_eop)         state_d = ST_BODY;
                    else if (need_extra) state_d = ST_EXTRA;
                    else                 state_d = ST_IDLE;
                end
            end
            ST_BODY: begin
                if (in_fire && in_eop) begin
                    state_d = need_extra ? ST_EXTRA : ST_IDLE;
                end
            end
            ST_EXTRA: begin
                if (out_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        out_valid = 1'b0;
        out_data  = in_data;
        out_sop   = start;
        out_eop   = in_eop;
        out_empty = in_empty;
        unique case (state_q)
            ST_EXTRA: begin
                out_valid = 1'b1;
                out_sop   = 1'b0;
                out_eop   = 1'b1;
                out_empty = EMPTY_W'(SLOT_W'(2*LANES - 1) - xslot_q);
                for (int i = 0; i < LANES; i++) begin
                    out_data[i*DW_W +: DW_W] =
                        (xslot_q == SLOT_W'(LANES + i)) ? xcrc_q : '0;
                end
            end
            ST_IDLE, ST_BODY: begin
                out_valid = in_valid && pkt_beat;
                if (start) begin
                    out_data[TD_BIT] = !cur_ex;
                end
                if (do_crc) begin
                    for (int i = 0; i < LANES; i++) begin
                        if (CNT_W'(i) >= valid_cnt) out_data[i*DW_W +: DW_W] = '0;
                        if (slot == SLOT_W'(i))     out_data[i*DW_W +: DW_W] = ~crc_new;
                    end
                    out_eop   = fits;
                    out_empty = fits ? EMPTY_W'(SLOT_W'(LANES - 1) - slot) : '0;
                end
            end
            default: out_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/ecrc_append_chk.sv
module ecrc_append_chk
    import ecrc_pkg::*;
#(
    parameter int LANES = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic                     in_ready,
    input logic                     in_sop,
    input logic                     in_eop,
    input logic                     out_valid,
    input logic                     out_ready,
    input logic [LANES*DW_W-1:0]    out_data,
    input logic                     out_sop,
    input logic                     out_eop,
    input logic [$clog2(LANES)-1:0] out_empty
);

    logic open_q;
    logic unused_chk;

    assign unused_chk = ^out_data;

    // Packet-open tracking seen from the input handshake.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q <= 1'b0;
        end else if (in_valid && in_ready) begin
            if (!open_q && in_sop && !in_eop) open_q <= 1'b1;
            else if (open_q && in_eop)        open_q <= 1'b0;
        end
    end

    AST_DIGEST_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sop && out_data[TYPE_LSB +: 5] != TYPE_CFG0) |-> out_data[TD_BIT]); // R1

    AST_CFG0_NO_DIGEST: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sop && out_data[TYPE_LSB +: 5] == TYPE_CFG0) |-> !out_data[TD_BIT]); // R5

    AST_SINGLE_BEAT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sop && out_eop && out_data[TYPE_LSB +: 5] != TYPE_CFG0) |-> (out_empty == '0)); // R4

    AST_EXTRA_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_eop && out_valid && !out_eop)
        |=> (out_valid && out_eop && !out_sop && !in_ready)); // R6

    AST_STRAY_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_sop && !open_q) |-> !out_valid); // R8

    AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid); // R10

endmodule

bind ecrc_append ecrc_append_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_sop    (in_sop),
    .in_eop    (in_eop),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_empty (out_empty)
);

// File: tb/ecrc_append_tb.sv
module ecrc_append_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_data = '0;
    logic         in_sop = 1'b0;
    logic         in_eop = 1'b0;
    logic [1:0]   in_empty = '0;
    logic         in_has_data = 1'b0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [127:0] out_data;
    logic         out_sop;
    logic         out_eop;
    logic [1:0]   out_empty;

    int checks = 0;
    int failures = 0;
    bit bp_en = 1'b0;

    typedef struct packed {
        logic [127:0] d;
        logic         sop;
        logic         eop;
        logic [1:0]   empty;
        logic         extra;
    } beat_t;

    beat_t exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    ecrc_append u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_data     (in_data),
        .in_sop      (in_sop),
        .in_eop      (in_eop),
        .in_empty    (in_empty),
        .in_has_data (in_has_data),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_data    (out_data),
        .out_sop     (out_sop),
        .out_eop     (out_eop),
        .out_empty   (out_empty)
    );

    // Reference CRC-32 step, taking word bits from the top down.
    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [31:0] w);
        logic [31:0] r;
        r = c;
        for (int k = 0; k < 32; k++) begin
            if (r[31] != w[31-k]) r = (r << 1) ^ 32'h04C11DB7;
            else                  r = r << 1;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s", req, what);
        end
    endtask

    // Monitor: compares each accepted output beat against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10", $sformatf("unexpected beat got=%h exp=none", out_data));
            end else begin
                beat_t e;
                string t;
                bit    ok;
                e  = exp_q.pop_front();
                t  = tag_q.pop_front();
                ok = (out_sop == e.sop) && (out_eop == e.eop) && (out_empty == e.empty);
                for (int i = 0; i < 4; i++) begin
                    if (i < 4 - int'(e.empty) && out_data[i*32 +: 32] != e.d[i*32 +: 32]) ok = 1'b0;
                end
                check(ok, t, $sformatf("beat got d=%h sop=%0b eop=%0b empty=%0d exp d=%h sop=%0b eop=%0b empty=%0d",
                      out_data, out_sop, out_eop, out_empty, e.d, e.sop, e.eop, e.empty));
                if (e.extra) begin
                    check(!in_ready, "R6", $sformatf("in_ready during extra beat got=%0b exp=0", in_ready));
                end
            end
        end
    end

    // Back-pressure generator.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            out_ready = bp_en ? (($urandom % 3) != 0) : 1'b1;
        end
    end

    task automatic drive_beat(input logic [127:0] d, input bit s, input bit e,
                              input logic [1:0] emp, input bit hd);
        in_valid    = 1'b1;
        in_data     = d;
        in_sop      = s;
        in_eop      = e;
        in_empty    = emp;
        in_has_data = hd;
        do @(negedge clk); while (!in_ready);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_eop   = 1'b0;
    endtask

    // Driver: builds a packet, pushes the expected output, then drives it.
    task automatic send_pkt(input logic [4:0] typ, input bit h4, input bit al,
                            input int npl, input bit td, input bit ep, input string tag);
        logic [31:0] inw[$];
        logic [31:0] outw[$];
        logic [31:0] addr;
        logic [31:0] crc;
        bit          ex;
        int          nin;
        int          nout;
        ex   = (typ == 5'b00100);
        addr = 32'hABCD_1230 | (al ? 32'h0 : 32'h4);
        inw.push_back({1'b0, (npl > 0), h4, typ, 8'h00, td, ep, 4'h0, 10'(npl)});
        inw.push_back(32'h0100_00FF);
        if (h4) inw.push_back(32'h0000_0001);
        inw.push_back(addr);
        crc = 32'hFFFF_FFFF;
        for (int i = 0; i < inw.size(); i++) begin
            logic [31:0] w;
            w = inw[i];
            if (i == 0) w = w | 32'h0000_C000;
            crc = ref_crc(crc, w);
        end
        if (npl > 0) begin
            if ((!h4 && al) || (h4 && !al)) inw.push_back(32'hDEAD_BEEF);
            for (int i = 0; i < npl; i++) begin
                logic [31:0] p;
                p   = $urandom;
                inw.push_back(p);
                crc = ref_crc(crc, p);
            end
        end
        crc = ~crc;
        outw = inw;
        outw[0][15] = !ex;
        if (!ex) begin
            if (npl > 0) begin
                outw.push_back(crc);
            end else begin
                if ((!h4 && al) || (h4 && !al)) outw.push_back(32'h0);
                outw.push_back(crc);
            end
        end
        nin  = (inw.size() + 3) / 4;
        nout = (outw.size() + 3) / 4;
        for (int b = 0; b < nout; b++) begin
            beat_t e;
            e.d = '0;
            for (int l = 0; l < 4; l++) begin
                if (b*4 + l < outw.size()) e.d[l*32 +: 32] = outw[b*4 + l];
            end
            e.sop   = (b == 0);
            e.eop   = (b == nout - 1);
            e.empty = (b == nout - 1) ? 2'(nout*4 - outw.size()) : 2'd0;
            e.extra = (b >= nin);
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
        for (int b = 0; b < nin; b++) begin
            logic [127:0] d;
            d = '0;
            for (int l = 0; l < 4; l++) begin
                if (b*4 + l < inw.size()) d[l*32 +: 32] = inw[b*4 + l];
            end
            drive_beat(d, b == 0, b == nin - 1,
                       (b == nin - 1) ? 2'(nin*4 - inw.size()) : 2'd0, npl > 0);
        end
    endtask

    task automatic send_stray();
        in_valid    = 1'b1;
        in_data     = {4{32'h1357_9BDF}};
        in_sop      = 1'b0;
        in_eop      = 1'b1;
        in_empty    = 2'd0;
        in_has_data = 1'b1;
        do @(negedge clk); while (!in_ready);
        check(!out_valid, "R8", $sformatf("stray beat out_valid got=%0b exp=0", out_valid));
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_eop   = 1'b0;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired got=running exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(!out_valid && in_ready == out_ready, "R9",
              $sformatf("in reset out_valid=%0b in_ready=%0b exp 0/%0b", out_valid, in_ready, out_ready));
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid, "R9", $sformatf("after reset out_valid got=%0b exp=0", out_valid));
        check(in_ready == 1'b1, "R9", $sformatf("after reset in_ready got=%0b exp=1", in_ready));
        @(posedge clk);
        #1;

        // Header-only packets, every size and alignment.
        send_pkt(5'b00000, 1'b0, 1'b0, 0, 1'b0, 1'b0, "R4");
        send_pkt(5'b00000, 1'b0, 1'b1, 0, 1'b0, 1'b0, "R4");
        send_pkt(5'b00000, 1'b1, 1'b1, 0, 1'b0, 1'b0, "R4");
        send_pkt(5'b00000, 1'b1, 1'b0, 0, 1'b1, 1'b1, "R4");
        send_pkt(5'b00101, 1'b0, 1'b0, 0, 1'b0, 1'b0, "R1");

        // Payload packets across every end-beat fill level.
        for (int n = 1; n <= 6; n++) begin
            send_pkt(5'b00000, 1'b0, 1'b1, n, 1'b0, 1'b0, "R3");
            send_pkt(5'b00000, 1'b0, 1'b0, n, 1'b0, 1'b0, "R3");
            send_pkt(5'b00000, 1'b1, 1'b0, n, 1'b0, 1'b0, "R7");
            send_pkt(5'b00000, 1'b1, 1'b1, n, 1'b0, 1'b0, "R3");
        end

        // Variant header bits do not alter the CRC.
        send_pkt(5'b00000, 1'b0, 1'b0, 2, 1'b0, 1'b1, "R2");
        send_pkt(5'b00000, 1'b1, 1'b0, 3, 1'b1, 1'b0, "R2");

        // Exempt configuration requests.
        send_pkt(5'b00100, 1'b0, 1'b0, 0, 1'b1, 1'b0, "R5");
        send_pkt(5'b00100, 1'b0, 1'b1, 1, 1'b1, 1'b0, "R5");
        send_pkt(5'b00100, 1'b0, 1'b0, 1, 1'b0, 1'b0, "R5");

        // Stray beat outside any packet.
        send_stray();
        send_pkt(5'b00000, 1'b0, 1'b1, 4, 1'b0, 1'b0, "R8");

        // Mixed traffic under back-pressure.
        bp_en = 1'b1;
        for (int k = 0; k < 60; k++) begin
            logic [4:0] typ;
            typ = ((k % 7) == 3) ? 5'b00100 : 5'b00000;
            send_pkt(typ, 1'($urandom % 2), 1'($urandom % 2), int'($urandom % 7),
                     1'($urandom % 2), 1'($urandom % 2), "R10");
        end

        while (exp_q.size() != 0) @(posedge clk);
        bp_en = 1'b0;
        repeat (5) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule